// File: doc/BRIEF.md
# Configurable Sequential Logic Cell

This block models a single logic cell of the kind tiled across a fuse-configured gate array. Its combinational half is a four-way selector: one data leg out of four is passed through, and the two select lines come from a two-input AND gate and a two-input OR gate on four control inputs. That result is always available on its own output. It also feeds a storage element that can be cleared, and static configuration inputs make that element either a rising-edge flip-flop or a level-sensitive latch.

Three configuration inputs shape the cell. One picks the clock that drives storage: either of two general routed clocks or the dedicated array clock. Another picks flip-flop or latch behaviour. A third decides whether the main cell output shows the combinational result or the stored bit. The configuration is meant to stay fixed while the cell runs. When it does change, a clear pulse should follow so that the stored bit starts from a known state.

Top module: `cfg_logic_cell`

## Requirements
- R1: `comb_o` equals `leg_i[{hi_sel, lo_sel}]`: leg 0 when both selects are 0, leg 1 when only the low select is 1, leg 2 when only the high select is 1, and leg 3 when both selects are 1.
- R2: The low select `lo_sel` is 1 exactly when `and_a_i` and `and_b_i` are both 1.
- R3: The high select `hi_sel` is 1 when `or_a_i` is 1, when `or_b_i` is 1, or when both are.
- R4: With `cfg_reg_out_i` = 0, `cell_o` follows `comb_o` with no clocking. With `cfg_reg_out_i` = 1, `cell_o` shows the stored bit and ignores changes on `comb_o`.
- R5: With `cfg_latch_i` = 0 (flip-flop), the stored bit takes the value of `comb_o` on each rising edge of the selected clock and holds it between edges.
- R6: With `cfg_latch_i` = 1 (latch), the stored bit follows `comb_o` while the selected clock is high and holds its last value while that clock is low.
- R7: `cfg_clk_sel_i` picks the storage clock: 2'b00 selects `clk_rt0_i`, 2'b01 selects `clk_rt1_i`, 2'b10 selects `clk_ded_i`, and 2'b11 acts as 2'b10. Activity on a clock that is not selected leaves the stored bit unchanged.
- R8: `clr_i` is an active-high asynchronous clear. It forces the stored bit to 0 at once in both storage modes and overrides a transparent latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| leg_i | input | 4 | Four data legs for the selector, indexed by {high select, low select} |
| and_a_i | input | 1 | First input of the AND gate that forms the low select |
| and_b_i | input | 1 | Second input of the AND gate that forms the low select |
| or_a_i | input | 1 | First input of the OR gate that forms the high select |
| or_b_i | input | 1 | Second input of the OR gate that forms the high select |
| clk_rt0_i | input | 1 | Routed clock network 0 |
| clk_rt1_i | input | 1 | Routed clock network 1 |
| clk_ded_i | input | 1 | Dedicated array clock |
| clr_i | input | 1 | Asynchronous clear of the storage element, active high |
| cfg_clk_sel_i | input | 2 | Storage clock select (00 routed 0, 01 routed 1, 10 or 11 dedicated) |
| cfg_latch_i | input | 1 | Storage mode: 0 for flip-flop, 1 for latch |
| cfg_reg_out_i | input | 1 | Output source: 0 for combinational, 1 for stored |
| comb_o | output | 1 | Combinational selector result |
| cell_o | output | 1 | Cell output, combinational or stored as configured |

## Verification
The selector is swept through all 256 combinations of the four legs and the four gate inputs. This separates an AND from an OR on either select, a swapped select order, and a wrong leg index. The sweep runs twice: once with the output showing the combinational result and once with it showing a cleared stored bit, which shows whether the output source switch works. For each of the four clock-select codes, both storage modes are stepped through. Pulses on the clocks that are not selected must leave the bit alone. In flip-flop mode, a change of input between edges must not show through. In latch mode, the input must pass while the clock is high and be held once it goes low. A clear applied during a transparent phase must win.

// File: rtl/lc_pkg.sv
// Package lc_pkg
// Shared constants and encodings for the configurable logic cell.
// Assumes one cell handles a single data bit and has two select lines.
package lc_pkg;

    localparam int LC_SEL_W  = 2;
    localparam int LC_LEGS   = 1 << LC_SEL_W;

    // Storage clock source. Code 11 is reserved and acts as the dedicated clock.
    typedef enum logic [LC_SEL_W-1:0] {
        LC_CLK_ROUTED0 = 2'b00,
        LC_CLK_ROUTED1 = 2'b01,
        LC_CLK_DEDIC   = 2'b10,
        LC_CLK_RSVD    = 2'b11
    } lc_clksrc_e;

    typedef enum logic {
        LC_MODE_FLOP  = 1'b0,
        LC_MODE_LATCH = 1'b1
    } lc_store_mode_e;

endpackage

// File: rtl/lc_select_mux.sv
// Module lc_select_mux
// Combinational core of the cell. An AND of one input pair and an OR of
// another pair form the two select lines, and those lines pick one of
// the data legs. Assumes leg index = {high select, low select}.
module lc_select_mux
    import lc_pkg::*;
(
    input  logic [LC_LEGS-1:0] leg_i,
    input  logic               and_a_i,
    input  logic               and_b_i,
    input  logic               or_a_i,
    input  logic               or_b_i,
    output logic               y_o
);

    logic [LC_SEL_W-1:0] pick;

    // Build the selects and choose a data leg.
    always_comb begin
        pick[0] = and_a_i & and_b_i;
        pick[1] = or_a_i | or_b_i;
        y_o     = leg_i[pick];
    end

endmodule

// File: rtl/lc_clock_pick.sv
// Module lc_clock_pick
// Routes one of three clock networks to the storage element.
// Assumes the select is static or is changed only while the cell is cleared.
module lc_clock_pick
    import lc_pkg::*;
(
    input  logic       clk_rt0_i,
    input  logic       clk_rt1_i,
    input  logic       clk_ded_i,
    input  lc_clksrc_e src_i,
    output logic       clk_o
);

    // Pick the clock network; the reserved code falls back to the dedicated clock.
    always_comb begin
        unique case (src_i)
            LC_CLK_ROUTED0: clk_o = clk_rt0_i;
            LC_CLK_ROUTED1: clk_o = clk_rt1_i;
            LC_CLK_DEDIC:   clk_o = clk_ded_i;
            LC_CLK_RSVD:    clk_o = clk_ded_i;
            default:        clk_o = clk_ded_i;
        endcase
    end

endmodule

// File: rtl/lc_store_elem.sv
// Module lc_store_elem
// Clearable storage bit that acts as a rising-edge flip-flop or as a
// latch that is transparent while the clock is high. Both forms are built
// and the mode input picks which one drives the output. Assumes the mode
// is static, and that a clear follows any change of mode.
module lc_store_elem
    import lc_pkg::*;
(
    input  logic           clk_i,
    input  logic           clr_i,
    input  lc_store_mode_e mode_i,
    input  logic           d_i,
    output logic           q_o
);

    logic flop_q;
    logic latch_q;

    // Edge storage with asynchronous clear.
    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) flop_q <= 1'b0;
        else       flop_q <= d_i;
    end

    // Level storage: clear wins, otherwise transparent while the clock is high.
    always_latch begin
        if (clr_i)      latch_q <= 1'b0;
        else if (clk_i) latch_q <= d_i;
    end

    // Present the form chosen by the mode.
    always_comb begin
        q_o = (mode_i == LC_MODE_LATCH) ? latch_q : flop_q;
    end

endmodule

// File: rtl/cfg_logic_cell.sv
// Module cfg_logic_cell
// One configurable logic cell: a select-gated four-leg selector, a clock
// source picker and a clearable storage bit, with a choice between a
// combinational and a stored output. Assumes the cfg_* inputs are static
// during operation.
module cfg_logic_cell
    import lc_pkg::*;
(
    input  logic [LC_LEGS-1:0]  leg_i,
    input  logic                and_a_i,
    input  logic                and_b_i,
    input  logic                or_a_i,
    input  logic                or_b_i,
    input  logic                clk_rt0_i,
    input  logic                clk_rt1_i,
    input  logic                clk_ded_i,
    input  logic                clr_i,
    input  logic [LC_SEL_W-1:0] cfg_clk_sel_i,
    input  logic                cfg_latch_i,
    input  logic                cfg_reg_out_i,
    output logic                comb_o,
    output logic                cell_o
);

    logic comb_y;
    logic store_clk;
    logic store_q;

    lc_select_mux u_mux (
        .leg_i   (leg_i),
        .and_a_i (and_a_i),
        .and_b_i (and_b_i),
        .or_a_i  (or_a_i),
        .or_b_i  (or_b_i),
        .y_o     (comb_y)
    );

    lc_clock_pick u_clk (
        .clk_rt0_i (clk_rt0_i),
        .clk_rt1_i (clk_rt1_i),
        .clk_ded_i (clk_ded_i),
        .src_i     (lc_clksrc_e'(cfg_clk_sel_i)),
        .clk_o     (store_clk)
    );

    lc_store_elem u_store (
        .clk_i  (store_clk),
        .clr_i  (clr_i),
        .mode_i (lc_store_mode_e'(cfg_latch_i)),
        .d_i    (comb_y),
        .q_o    (store_q)
    );

    // Drive the combinational result and the configured cell output.
    always_comb begin
        comb_o = comb_y;
        cell_o = cfg_reg_out_i ? store_q : comb_y;
    end

endmodule

// File: rtl/lc_cell_checker.sv
// Module lc_cell_checker
// Property checks for cfg_logic_cell, attached through bind. Sampling is on
// the edges of the cell's own clocks. Assumes that a clear follows every
// change of configuration.
module lc_cell_checker (
    input logic [3:0] leg_i,
    input logic       and_a_i,
    input logic       and_b_i,
    input logic       or_a_i,
    input logic       or_b_i,
    input logic       clk_rt0_i,
    input logic       clk_ded_i,
    input logic       clr_i,
    input logic [1:0] cfg_clk_sel_i,
    input logic       cfg_latch_i,
    input logic       cfg_reg_out_i,
    input logic       comb_o,
    input logic       cell_o,
    input logic       store_q
);

    // R2: an incomplete AND pair with the OR pair low gives leg 0
    assert_leg0_R2: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        ((!and_a_i || !and_b_i) && !or_a_i && !or_b_i) |-> (comb_o == leg_i[0]));

    // R2: a complete AND pair with the OR pair low gives leg 1
    assert_leg1_R2: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        (and_a_i && and_b_i && !or_a_i && !or_b_i) |-> (comb_o == leg_i[1]));

    // R3: either OR input high, with the AND pair incomplete, gives leg 2
    assert_leg2_R3: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        ((or_a_i || or_b_i) && !(and_a_i && and_b_i)) |-> (comb_o == leg_i[2]));

    // R1: both selects high give leg 3
    assert_leg3_R1: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        ((or_a_i || or_b_i) && and_a_i && and_b_i) |-> (comb_o == leg_i[3]));

    // R4: combinational output source
    assert_out_comb_R4: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        !cfg_reg_out_i |-> (cell_o == comb_o));

    // R4: stored output source
    assert_out_store_R4: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        cfg_reg_out_i |-> (cell_o == store_q));

    // R5: flip-flop on the dedicated clock holds what it took at the previous edge
    assert_flop_capture_R5: assert property (@(posedge clk_ded_i) disable iff (clr_i)
        (!cfg_latch_i && cfg_clk_sel_i[1]) ##1 (!cfg_latch_i && cfg_clk_sel_i[1])
        |-> (store_q == $past(comb_o)));

    // R7: flip-flop on routed clock 0 captures on that clock's edges
    assert_rt0_capture_R7: assert property (@(posedge clk_rt0_i) disable iff (clr_i)
        (!cfg_latch_i && cfg_clk_sel_i == 2'b00) ##1 (!cfg_latch_i && cfg_clk_sel_i == 2'b00)
        |-> (store_q == $past(comb_o)));

    // R8: a clear held over a dedicated clock edge keeps the stored bit at 0
    always @(posedge clk_ded_i) begin
        if (clr_i) begin
            assert_clear_R8: assert (store_q == 1'b0);
        end
    end

endmodule

bind cfg_logic_cell lc_cell_checker u_chk (
    .leg_i         (leg_i),
    .and_a_i       (and_a_i),
    .and_b_i       (and_b_i),
    .or_a_i        (or_a_i),
    .or_b_i        (or_b_i),
    .clk_rt0_i     (clk_rt0_i),
    .clk_ded_i     (clk_ded_i),
    .clr_i         (clr_i),
    .cfg_clk_sel_i (cfg_clk_sel_i),
    .cfg_latch_i   (cfg_latch_i),
    .cfg_reg_out_i (cfg_reg_out_i),
    .comb_o        (comb_o),
    .cell_o        (cell_o),
    .store_q       (store_q)
);

// File: tb/cfg_logic_cell_tb.sv
// Bench cfg_logic_cell_tb
// Exhaustive sweep of the selector, then every clock code in both storage
// modes. Expected values are computed here from the requirement text.
module cfg_logic_cell_tb;

    logic       clk = 1'b0;
    logic [3:0] leg_i = 4'h0;
    logic       and_a_i = 1'b0, and_b_i = 1'b0, or_a_i = 1'b0, or_b_i = 1'b0;
    logic       clk_rt0_i = 1'b0, clk_rt1_i = 1'b0, clk_ded_i = 1'b0;
    logic       clr_i = 1'b1;
    logic [1:0] cfg_clk_sel_i = 2'b00;
    logic       cfg_latch_i = 1'b0;
    logic       cfg_reg_out_i = 1'b0;
    logic       comb_o, cell_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cfg_logic_cell u_dut (
        .leg_i         (leg_i),
        .and_a_i       (and_a_i),
        .and_b_i       (and_b_i),
        .or_a_i        (or_a_i),
        .or_b_i        (or_b_i),
        .clk_rt0_i     (clk_rt0_i),
        .clk_rt1_i     (clk_rt1_i),
        .clk_ded_i     (clk_ded_i),
        .clr_i         (clr_i),
        .cfg_clk_sel_i (cfg_clk_sel_i),
        .cfg_latch_i   (cfg_latch_i),
        .cfg_reg_out_i (cfg_reg_out_i),
        .comb_o        (comb_o),
        .cell_o        (cell_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic set_clk(input int which, input logic v);
        case (which)
            0:       clk_rt0_i = v;
            1:       clk_rt1_i = v;
            default: clk_ded_i = v;
        endcase
        @(negedge clk);
    endtask

    task automatic pulse(input int which);
        set_clk(which, 1'b1);
        set_clk(which, 1'b0);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic clear_pulse();
        clr_i = 1'b1;
        settle();
        clr_i = 1'b0;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int tgt;
        settle();
        // reset state: clear held, stored output source
        cfg_reg_out_i = 1'b1;
        settle();
        chk(cell_o, 1'b0, "R8 reset state");
        clr_i = 1'b0;
        settle();

        // R1 R2 R3 R4: exhaustive selector sweep in both output modes
        for (int ro = 0; ro < 2; ro++) begin
            cfg_reg_out_i = ro[0];
            for (int v = 0; v < 256; v++) begin
                int s0, s1, exp;
                leg_i   = v[3:0];
                and_a_i = v[4];
                and_b_i = v[5];
                or_a_i  = v[6];
                or_b_i  = v[7];
                s0  = (v[4] && v[5]) ? 1 : 0;
                s1  = (v[6] || v[7]) ? 1 : 0;
                exp = (v >> (s1 * 2 + s0)) & 1;
                settle();
                chk(comb_o, exp[0], "R1 R2 R3 selector");
                chk(cell_o, (ro == 0) ? exp[0] : 1'b0, "R4 output source");
                pulse(2);
            end
        end

        // R5 R6 R7 R8: each clock code in both storage modes
        and_a_i = 1'b0; and_b_i = 1'b0; or_a_i = 1'b0; or_b_i = 1'b0;
        cfg_reg_out_i = 1'b1;
        for (int s = 0; s < 4; s++) begin
            tgt = (s >= 2) ? 2 : s;
            cfg_clk_sel_i = s[1:0];

            // flip-flop mode
            cfg_latch_i = 1'b0;
            clear_pulse();
            leg_i = 4'hF;
            settle();
            for (int c = 0; c < 3; c++) begin
                if (c != tgt) begin
                    pulse(c);
                    chk(cell_o, 1'b0, "R7 unselected clock ignored (flop)");
                end
            end
            pulse(tgt);
            chk(cell_o, 1'b1, "R5 capture on rising edge");
            leg_i = 4'h0;
            settle();
            chk(cell_o, 1'b1, "R5 hold between edges");
            pulse(tgt);
            chk(cell_o, 1'b0, "R5 capture of new value");
            leg_i = 4'hF;
            pulse(tgt);
            chk(cell_o, 1'b1, "R5 capture again");
            clr_i = 1'b1;
            settle();
            chk(cell_o, 1'b0, "R8 clear in flop mode");

            // latch mode
            cfg_latch_i = 1'b1;
            clear_pulse();
            leg_i = 4'hF;
            settle();
            for (int c = 0; c < 3; c++) begin
                if (c != tgt) begin
                    set_clk(c, 1'b1);
                    chk(cell_o, 1'b0, "R7 unselected clock ignored (latch)");
                    set_clk(c, 1'b0);
                end
            end
            set_clk(tgt, 1'b1);
            chk(cell_o, 1'b1, "R6 transparent while high");
            leg_i = 4'h0;
            settle();
            chk(cell_o, 1'b0, "R6 follows input while high");
            leg_i = 4'hF;
            settle();
            set_clk(tgt, 1'b0);
            leg_i = 4'h0;
            settle();
            chk(cell_o, 1'b1, "R6 holds while low");
            set_clk(tgt, 1'b1);
            chk(cell_o, 1'b0, "R6 reopens on high");
            leg_i = 4'hF;
            settle();
            clr_i = 1'b1;
            settle();
            chk(cell_o, 1'b0, "R8 clear overrides transparent latch");
            set_clk(tgt, 1'b0);
            clr_i = 1'b0;
            settle();
            chk(cell_o, 1'b0, "R8 cleared value held");
            chk(comb_o, 1'b1, "R1 comb unaffected by storage");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule